// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a target on a two-wire serial bus that owns a small bank of 8-bit registers. A controller reaches the bank through an 8-bit register pointer. A write transaction carries the pointer value first and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then moves on to the next register. A read transaction first sets the pointer with a short write. It then issues a repeated START and the address with the read bit, and the target returns bytes starting at the pointer.

The bus lines are sampled in the system clock domain. Each line passes through a two-flop synchronizer, and edge detection runs on the synchronized values. START and STOP are recognized from SDA edges while SCL is high. The target never drives a line high. It only asserts an open-drain enable that pulls SDA low. A parameter selects one of two address modes. In the first, the target matches a 7-bit address. In the second, it matches a two-frame 10-bit address, which can share a bus with 7-bit devices. Every register is also presented in parallel on a flat output vector.

Top module: `i2c_reg_target`

## Requirements
- R1: In 7-bit mode the target drives ACK after the first frame only when its upper seven bits equal the device address. On a mismatch it keeps SDA released until the next START or STOP, and it stores nothing.
- R2: In a write, the byte after the address frame is a register index. The target ACKs it and loads the pointer with its low log2(NUM_REGS) bits, so an index of 8'h0E in an 8-register bank selects register 6.
- R3: Each later write byte is ACKed and stored at the pointer. The pointer then increments, and it wraps from the last register back to register 0.
- R4: After a repeated START and an address frame with the read bit (bit 0 = 1), the target ACKs and sends the register at the pointer, MSB first. The pointer advances after every byte sent. A read with no preceding index resumes from the pointer left by the previous transaction.
- R5: When the controller answers a sent byte with NACK (SDA high in the ninth bit), the target releases SDA. It stays released until a START or STOP.
- R6: In 10-bit mode the first frame 11110, A9, A8, 0 is ACKed when A9:A8 match. The second frame is ACKed only when it equals address bits 7:0. After any mismatch the target keeps SDA released.
- R7: In 10-bit mode the frame 11110, A9, A8, 1 is ACKed only when the full 10-bit address matched earlier in the same transaction. A STOP clears that match.
- R8: A START or repeated START restarts address decoding with SDA released. A STOP returns the target to idle with SDA released.
- R9: The target begins pulling SDA low only while SCL is low.
- R10: After reset every register reads zero, the pointer is zero and SDA is released.
- R11: Byte i of regs_o (bits 8i+7 down to 8i) always holds register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | All registers, register i in bits 8i+7:8i |

## Verification
The bench places two instances on a single wired-AND SDA line. Both use NUM_REGS = 8. One runs in 7-bit mode at address 7'h3A. The other runs in 10-bit mode at address 10'h2C5. Because every frame reaches both targets, each instance is checked for staying silent during the other's traffic, including 10-bit prefixes that a 7-bit device must reject. The small bank brings pointer wrap within reach in short bursts, and random index bytes above 7 exercise the index truncation.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_LO,
        ST_INDEX,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_tgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        line_pair_t meta;
        line_pair_t sync;
        line_pair_t prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = '{scl: scl_i, sda: sda_i};
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    // Idle bus is high on both lines, so reset to ones to avoid false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_o      = s_q.sync.scl;
    assign sda_o      = s_q.sync.sda;
    assign scl_rise_o =  s_q.sync.scl & ~s_q.prev.scl;
    assign scl_fall_o = ~s_q.sync.scl &  s_q.prev.scl;
    assign start_o    =  s_q.sync.scl & s_q.prev.scl &  s_q.prev.sda & ~s_q.sync.sda;
    assign stop_o     =  s_q.sync.scl & s_q.prev.scl & ~s_q.prev.sda &  s_q.sync.sda;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS = 8,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [PTR_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    input  logic [PTR_W-1:0]      rd_idx_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en_i && (wr_idx_i == PTR_W'(g))) r_d = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign regs_o[g*8 +: 8] = r_q;
    end

    assign rd_data_o = regs_o[rd_idx_i*8 +: 8];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (regs_o[$past(wr_idx_i)*8 +: 8] == $past(wr_data_i)));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter bit         TEN_BIT  = 1'b0,
    parameter logic [9:0] DEV_ADDR = 10'h03A,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rd_data_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             sda_oe_o,
    output tgt_state_e       state_o
);

    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef struct packed {
        tgt_state_e       st;
        logic [3:0]       cnt;
        logic             ack_ph;
        logic [7:0]       sh;
        logic [PTR_W-1:0] ptr;
        logic             oe;
        logic             ten_sel;
        logic             nack;
    } fsm_t;

    fsm_t n, q;

    always_comb begin
        n         = q;
        wr_en_o   = 1'b0;
        wr_idx_o  = q.ptr;
        wr_data_o = q.sh;

        if (stop_i) begin
            n.st      = ST_IDLE;
            n.cnt     = '0;
            n.ack_ph  = 1'b0;
            n.oe      = 1'b0;
            n.ten_sel = 1'b0;
        end else if (start_i) begin
            n.st     = ST_ADDR;
            n.cnt    = '0;
            n.ack_ph = 1'b0;
            n.oe     = 1'b0;
            n.nack   = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE, ST_IGNORE: n = q;

                ST_RDATA: begin
                    if (scl_rise_i) begin
                        if (q.ack_ph) n.nack = sda_i;
                        else          n.cnt  = q.cnt + 4'd1;
                    end
                    if (scl_fall_i) begin
                        if (!q.ack_ph) begin
                            if (q.cnt == 4'd8) begin
                                n.oe     = 1'b0;
                                n.ack_ph = 1'b1;
                                n.ptr    = q.ptr + PTR_W'(1);
                            end else begin
                                n.sh = {q.sh[6:0], 1'b0};
                                n.oe = ~q.sh[6];
                            end
                        end else begin
                            n.ack_ph = 1'b0;
                            n.cnt    = '0;
                            if (q.nack) begin
                                n.st = ST_IGNORE;
                                n.oe = 1'b0;
                            end else begin
                                n.sh = rd_data_i;
                                n.oe = ~rd_data_i[7];
                            end
                        end
                    end
                end

                default: begin
                    if (scl_rise_i && !q.ack_ph) begin
                        n.sh  = {q.sh[6:0], sda_i};
                        n.cnt = q.cnt + 4'd1;
                    end
                    if (scl_fall_i) begin
                        if (q.ack_ph) begin
                            n.ack_ph = 1'b0;
                            n.cnt    = '0;
                            n.oe     = 1'b0;
                        end else if (q.cnt == 4'd8) begin
                            n.ack_ph = 1'b1;
                            n.nack   = 1'b0;
                            n.oe     = 1'b1;
                            case (q.st)
                                ST_ADDR: begin
                                    if (TEN_BIT) begin
                                        if (q.sh[7:3] == TEN_PREFIX && q.sh[2:1] == DEV_ADDR[9:8]) begin
                                            if (!q.sh[0]) begin
                                                n.st      = ST_ADDR_LO;
                                                n.ten_sel = 1'b0;
                                            end else if (q.ten_sel) begin
                                                n.st = ST_RDATA;
                                            end else begin
                                                n.st = ST_IGNORE;
                                                n.oe = 1'b0;
                                            end
                                        end else begin
                                            n.st = ST_IGNORE;
                                            n.oe = 1'b0;
                                        end
                                    end else begin
                                        if (q.sh[7:1] == DEV_ADDR[6:0]) begin
                                            n.st = q.sh[0] ? ST_RDATA : ST_INDEX;
                                        end else begin
                                            n.st = ST_IGNORE;
                                            n.oe = 1'b0;
                                        end
                                    end
                                end
                                ST_ADDR_LO: begin
                                    if (q.sh == DEV_ADDR[7:0]) begin
                                        n.st      = ST_INDEX;
                                        n.ten_sel = 1'b1;
                                    end else begin
                                        n.st = ST_IGNORE;
                                        n.oe = 1'b0;
                                    end
                                end
                                ST_INDEX: begin
                                    n.ptr = q.sh[PTR_W-1:0];
                                    n.st  = ST_WDATA;
                                end
                                default: begin
                                    wr_en_o = 1'b1;
                                    n.ptr   = q.ptr + PTR_W'(1);
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign rd_idx_o = q.ptr;
    assign sda_oe_o = q.oe;
    assign state_o  = q.st;

    // R9
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(!scl_i));

    // R5
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> !q.oe);

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter bit         TEN_BIT  = 1'b0,
    parameter logic [9:0] DEV_ADDR = 10'h03A,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;
    tgt_state_e       st_w;

    i2c_line_sync i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_tgt_fsm #(
        .NUM_REGS (NUM_REGS),
        .TEN_BIT  (TEN_BIT),
        .DEV_ADDR (DEV_ADDR)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .rd_idx_o   (rd_idx),
        .sda_oe_o   (sda_oe_o),
        .state_o    (st_w)
    );

    i2c_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    // R8
    start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (st_w == ST_ADDR) && !sda_oe_o);

    // R8
    stop_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (st_w == ST_IDLE) && !sda_oe_o);

endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

    localparam int NREG = 8;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic oe7, oe10, sda_line;
    logic [NREG*8-1:0] regs7, regs10;

    assign sda_line = sda_drv & ~oe7 & ~oe10;

    i2c_reg_target #(.NUM_REGS(NREG), .TEN_BIT(1'b0), .DEV_ADDR(10'h03A)) i_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(oe7), .regs_o(regs7));

    i2c_reg_target #(.NUM_REGS(NREG), .TEN_BIT(1'b1), .DEV_ADDR(10'h2C5)) i_i2c_reg_target_ten (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe_o(oe10), .regs_o(regs10));

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [2][NREG];
    int mptr [2];
    bit done = 1'b0;

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*8-1:0] packm(input int d);
        logic [NREG*8-1:0] v;
        for (int r = 0; r < NREG; r++) v[r*8 +: 8] = mdl[d][r];
        return v;
    endfunction

    task automatic bus_start();
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(Q);
            scl_drv = 1'b1; wq(2*Q);
            scl_drv = 1'b0; wq(Q);
        end
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_drv = 1'b1; wq(Q);
            b[i] = sda_line;
            wq(Q);
            scl_drv = 1'b0; wq(Q);
        end
        sda_drv = nack; wq(Q);
        scl_drv = 1'b1; wq(2*Q);
        scl_drv = 1'b0; wq(Q);
        sda_drv = 1'b1;
    endtask

    task automatic addr_write(input int d);
        bit a;
        if (d == 1) begin
            send_byte(8'hF4, a); check("R6 upper frame ack", 64'(a), 64'd1);
            send_byte(8'hC5, a); check("R6 lower frame ack", 64'(a), 64'd1);
        end else begin
            send_byte(8'h74, a); check("R1 address ack", 64'(a), 64'd1);
        end
    endtask

    task automatic do_write(input int d, input logic [7:0] idx, input int n);
        bit a;
        logic [7:0] dat;
        bus_start();
        addr_write(d);
        send_byte(idx, a); check("R2 index ack", 64'(a), 64'd1);
        mptr[d] = int'(idx) % NREG;
        for (int k = 0; k < n; k++) begin
            dat = 8'($urandom);
            send_byte(dat, a); check("R3 data ack", 64'(a), 64'd1);
            mdl[d][mptr[d]] = dat;
            mptr[d] = (mptr[d] + 1) % NREG;
        end
        bus_stop();
        check("R11 port 7-bit target", 64'(regs7), 64'(packm(0)));
        check("R11 port 10-bit target", 64'(regs10), 64'(packm(1)));
    endtask

    task automatic do_read(input int d, input bit set_idx, input logic [7:0] idx, input int n);
        bit a;
        logic [7:0] b;
        bus_start();
        if (set_idx) begin
            addr_write(d);
            send_byte(idx, a); check("R2 index ack", 64'(a), 64'd1);
            mptr[d] = int'(idx) % NREG;
            bus_start();
        end
        if (d == 1) begin
            send_byte(8'hF5, a); check("R7 read frame ack", 64'(a), 64'd1);
        end else begin
            send_byte(8'h75, a); check("R4 read address ack", 64'(a), 64'd1);
        end
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            check("R4 read data", 64'(b), 64'(mdl[d][mptr[d]]));
            mptr[d] = (mptr[d] + 1) % NREG;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        void'($urandom(32'd4242));
        for (int d = 0; d < 2; d++) begin
            mptr[d] = 0;
            for (int r = 0; r < NREG; r++) mdl[d][r] = 8'h00;
        end
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R10: reset state
        check("R10 regs 7-bit", 64'(regs7), 64'd0);
        check("R10 regs 10-bit", 64'(regs10), 64'd0);
        check("R10 sda released", 64'(sda_line), 64'd1);
        do_read(0, 1'b0, 8'h00, 1);   // R10: pointer starts at 0

        // R1: wrong 7-bit address, nothing acked or stored
        bus_start();
        send_byte(8'h76, a); check("R1 wrong address no ack", 64'(a), 64'd0);
        send_byte(8'h02, a); check("R1 released after mismatch", 64'(a), 64'd0);
        send_byte(8'h5A, a); check("R1 released after mismatch", 64'(a), 64'd0);
        bus_stop();
        check("R1 regs unchanged", 64'(regs7), 64'(packm(0)));

        // R2 R3: index truncation and wrap past the last register
        do_write(0, 8'h0E, 4);
        do_read(0, 1'b1, 8'h06, 4);

        // R6: 10-bit write, then read with repeated START
        do_write(1, 8'h02, 3);
        do_read(1, 1'b1, 8'h02, 3);

        // R6: lower frame mismatch
        bus_start();
        send_byte(8'hF4, a); check("R6 upper frame ack", 64'(a), 64'd1);
        send_byte(8'hC4, a); check("R6 lower mismatch no ack", 64'(a), 64'd0);
        send_byte(8'h01, a); check("R6 released after mismatch", 64'(a), 64'd0);
        bus_stop();
        check("R6 regs unchanged", 64'(regs10), 64'(packm(1)));

        // R7: read frame without prior full match in this transaction
        bus_start();
        send_byte(8'hF5, a); check("R7 read frame without match", 64'(a), 64'd0);
        bus_stop();

        // R5: NACK releases SDA; R4: pointer kept for the next read
        bus_start();
        addr_write(0);
        send_byte(8'h03, a); check("R2 index ack", 64'(a), 64'd1);
        mptr[0] = 3;
        bus_start();
        send_byte(8'h75, a); check("R4 read address ack", 64'(a), 64'd1);
        recv_byte(1'b1, b); check("R4 read data", 64'(b), 64'(mdl[0][3]));
        mptr[0] = 4;
        recv_byte(1'b0, b); check("R5 released after nack", 64'(b), 64'hFF);
        bus_stop();
        do_read(0, 1'b0, 8'h00, 2);

        // R8: STOP then fresh START works for both targets
        for (int it = 0; it < 30; it++) begin
            int d;
            int n;
            logic [7:0] idx;
            d   = int'($urandom % 2);
            n   = 1 + int'($urandom % 4);
            idx = 8'($urandom);
            if ($urandom % 2 == 0) do_write(d, idx, n);
            else                   do_read(d, 1'b1, idx, n);
        end
        check("R8 idle released", 64'(sda_line), 64'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule